// File: doc/BRIEF.md
# Single-Bit Error Locator Controller

This block sequences an 8-bit signature register over a 256-bit serial stream and then reuses the same address counter to find where a single-bit error sits. The stream is fetched one bit per cycle from an external bit source. The block drives the source address and reads the returned bit in the same cycle. The signature register divides the stream by the polynomial x^8+x^4+x^3+x^2+1. A two-state controller (running, finished) decides when the walk ends and what the 8-bit display shows.

In check mode the whole stream is shifted in and the final remainder is displayed. A stream whose last eight bits are the correct parity gives a remainder of zero. In locate mode the register is restarted from the value 1 and clocked with zeros, so after c steps it holds x^c reduced by the polynomial. The run stops at the first step whose register value equals the 8-bit switch value. The count at that step is the error's distance from the end of the stream. If the count runs out with no match, a no-error flag is raised. The mode is sampled while reset is held and stays fixed for the whole run.

Top module: `elp_locator`

## Requirements
- R1: A clock edge with rst_n low (synchronous, active low) puts the block in the running state with count 0, done=0, no_err=0 and display=0. It captures mode_sel (1 = check, 0 = locate) and seeds the signature with 0 in check mode or 1 in locate mode.
- R2: While running, the count advances by one on each enabled cycle, and src_addr always equals the count. In check mode done rises on the edge that shifts in the bit at address 255, which is exactly 256 cycles after reset is released.
- R3: On each enabled cycle the signature s becomes t = (s<<1)|b. When bit 8 of t is set, t is XORed with 0x11D. Here b is src_bit in check mode and 0 in locate mode.
- R4: In check mode, once done is high the display shows the final signature. A stream whose bits 248+j equal bit 7-j of the remainder of the same stream with its last eight bits zeroed gives display 0.
- R5: In locate mode the first running cycle whose signature equals switch_val ends the run. In that cycle shift_en is 0 and the count holds. The display then shows the count, which is 255-q for a single flipped stream bit at index q (1 ≤ q ≤ 255), and no_err stays 0.
- R6: In locate mode, if the count reaches 255 with no match, the run ends after that cycle with no_err=1 and display=0.
- R7: In check mode switch_val has no effect: the run always takes 256 cycles and no_err stays 0.
- R8: Changes on mode_sel while rst_n is high have no effect on the run.
- R9: Once done is high it stays high until reset, shift_en is 0, and src_addr and display do not change.
- R10: While done is low, display is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; also samples mode_sel |
| mode_sel | input | 1 | 1 = check, 0 = locate; sampled during reset |
| switch_val | input | 8 | Pattern to match in locate mode |
| src_bit | input | 1 | Stream bit returned by the source for src_addr |
| src_addr | output | 8 | Stream bit address (the count) |
| shift_en | output | 1 | Enable for the count and the signature register |
| done | output | 1 | Run finished |
| no_err | output | 1 | Locate run ended with no match |
| display | output | 8 | Signature, error position or zero |

## Verification
The bench targets the stop cycle. A controller that stopped one step late in locate mode would report a position off by one. A controller that missed the terminal count would run on and overwrite the signature. It pairs a valid codeword with single-bit corruptions near both ends of the stream, including the final bit, which matches in the very first cycle. A switch value of zero can never match and must raise the no-error flag. The bench also drives a switch value that the check-mode signature passes through and toggles the mode input mid-run; a design that reacted to either would end early or change its result.

// File: rtl/elp_pkg.sv
package elp_pkg;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_FINISH = 1'b1
  } elp_state_t;

  typedef enum logic {
    MODE_LOCATE = 1'b0,
    MODE_CHECK  = 1'b1
  } elp_mode_t;

  localparam int unsigned ELP_SIG_W = 8;
  localparam logic [ELP_SIG_W-1:0] ELP_TAPS = 8'h1D;

endpackage

// File: rtl/elp_counter.sv
module elp_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         tc
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic at_end(input logic [W-1:0] v);
    return &v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (en) begin
      count <= count + ONE;
    end
  end

  assign tc = at_end(count);

endmodule

// File: rtl/elp_sig_reg.sv
module elp_sig_reg #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  TAPS = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_one,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] state
);

  logic         feedback;
  logic [W-1:0] nxt;

  assign feedback = state[W-1];
  assign nxt[0]   = feedback ^ din;

  for (genvar k = 1; k < W; k++) begin : g_bit
    if (TAPS[k]) begin : g_tap
      assign nxt[k] = state[k-1] ^ feedback;
    end else begin : g_pass
      assign nxt[k] = state[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= {{(W-1){1'b0}}, seed_one};
    end else if (en) begin
      state <= nxt;
    end
  end

endmodule

// File: rtl/elp_cmp.sv
module elp_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);

  function automatic logic same(input logic [W-1:0] x, input logic [W-1:0] y);
    return ~|(x ^ y);
  endfunction

  assign eq = same(a, b);

endmodule

// File: rtl/elp_fsm.sv
module elp_fsm
  import elp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_in,
  input  logic       tc,
  input  logic       match,
  output elp_mode_t  mode_q,
  output elp_state_t state,
  output logic       found,
  output logic       hit,
  output logic       step_en
);

  assign hit     = (state == ST_RUN) && (mode_q == MODE_LOCATE) && match;
  assign step_en = (state == ST_RUN) && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      mode_q <= elp_mode_t'(mode_in);
      found  <= 1'b0;
    end else if (state == ST_RUN) begin
      if (hit) begin
        state <= ST_FINISH;
        found <= 1'b1;
      end else if (tc) begin
        state <= ST_FINISH;
      end
    end
  end

endmodule

// File: rtl/elp_locator.sv
module elp_locator
  import elp_pkg::*;
#(
  parameter int unsigned  W    = ELP_SIG_W,
  parameter logic [W-1:0] TAPS = ELP_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_sel,
  input  logic [W-1:0] switch_val,
  input  logic         src_bit,
  output logic [W-1:0] src_addr,
  output logic         shift_en,
  output logic         done,
  output logic         no_err,
  output logic [W-1:0] display
);

  elp_mode_t   mode_q;
  elp_state_t  state;
  logic        found;
  logic        locate_hit;
  logic        cnt_tc;
  logic        sig_match;
  logic        mode_is_check;
  logic        sig_din;
  logic [W-1:0] count;
  logic [W-1:0] sig;

  function automatic logic [W-1:0] pick_display(
    input logic         fin,
    input logic         chk_mode,
    input logic         fnd,
    input logic [W-1:0] s,
    input logic [W-1:0] pos
  );
    if (!fin)     return '0;
    if (chk_mode) return s;
    if (fnd)      return pos;
    return '0;
  endfunction

  assign mode_is_check = (mode_q == MODE_CHECK);
  assign sig_din       = mode_is_check & src_bit;

  elp_counter #(.W(W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (shift_en),
    .count (count),
    .tc    (cnt_tc)
  );

  elp_sig_reg #(.W(W), .TAPS(TAPS)) u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_one (~mode_sel),
    .en       (shift_en),
    .din      (sig_din),
    .state    (sig)
  );

  elp_cmp #(.W(W)) u_cmp (
    .a  (sig),
    .b  (switch_val),
    .eq (sig_match)
  );

  elp_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (mode_sel),
    .tc      (cnt_tc),
    .match   (sig_match),
    .mode_q  (mode_q),
    .state   (state),
    .found   (found),
    .hit     (locate_hit),
    .step_en (shift_en)
  );

  assign src_addr = count;
  assign done     = (state == ST_FINISH);
  assign no_err   = done && !mode_is_check && !found;
  assign display  = pick_display(done, mode_is_check, found, sig, count);

endmodule

// File: rtl/elp_locator_chk.sv
module elp_locator_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_is_check,
  input logic         cnt_tc,
  input logic         locate_hit,
  input logic         shift_en,
  input logic         done,
  input logic         no_err,
  input logic [W-1:0] src_addr,
  input logic [W-1:0] display
);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_done_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !shift_en);

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(src_addr) && $stable(display)));

  assert_blank_display_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (display == '0));

  assert_addr_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (src_addr == W'($past(src_addr) + 1'b1)));

  assert_tc_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && cnt_tc && shift_en) |=> done);

  assert_hit_reports_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locate_hit |=> (done && !no_err && display == $past(src_addr)));

  assert_noerr_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_err |-> (done && display == '0 && !mode_is_check));

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_is_check));

  assert_check_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_check |-> !no_err);

endmodule

bind elp_locator elp_locator_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_is_check (mode_is_check),
  .cnt_tc        (cnt_tc),
  .locate_hit    (locate_hit),
  .shift_en      (shift_en),
  .done          (done),
  .no_err        (no_err),
  .src_addr      (src_addr),
  .display       (display)
);

// File: tb/test_elp_locator.sv
module test_elp_locator;

  localparam int W = 8;
  localparam int N = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_sel = 1'b1;
  logic [W-1:0] switch_val = '0;
  logic [N-1:0] stream = '0;
  logic         src_bit;
  logic [W-1:0] src_addr;
  logic         shift_en;
  logic         done;
  logic         no_err;
  logic [W-1:0] display;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign src_bit = stream[src_addr];

  elp_locator i_elp_locator (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .switch_val (switch_val),
    .src_bit    (src_bit),
    .src_addr   (src_addr),
    .shift_en   (shift_en),
    .done       (done),
    .no_err     (no_err),
    .display    (display)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // polynomial remainder step, integer arithmetic
  function automatic int poly_step(input int s, input int b);
    int t;
    t = (s << 1) | b;
    if (t >= 256) t = t ^ 285;
    return t;
  endfunction

  function automatic int rem_prefix(input logic [N-1:0] v, input int len);
    int s = 0;
    for (int i = 0; i < len; i++) s = poly_step(s, int'(v[i]));
    return s;
  endfunction

  function automatic int power_of_x(input int d);
    int s = 1;
    for (int i = 0; i < d; i++) s = poly_step(s, 0);
    return s;
  endfunction

  // behavioural reference model
  int m_cnt, m_sig;
  bit m_mode, m_done, m_found, model_ready = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = mode_sel; m_cnt = 0; m_sig = mode_sel ? 0 : 1;
      m_done = 0; m_found = 0; model_ready = 1;
    end else if (!m_done) begin
      if (!m_mode && m_sig == int'(switch_val)) begin
        m_done = 1; m_found = 1;
      end else begin
        m_sig = poly_step(m_sig, m_mode ? int'(stream[m_cnt]) : 0);
        if (m_cnt == N - 1) m_done = 1;
        m_cnt = (m_cnt + 1) % N;
      end
    end
  end

  always @(negedge clk) begin
    if (model_ready && !finished) begin
      bit exp_en, exp_ne;
      int exp_disp;
      exp_en = !m_done && !(!m_mode && m_sig == int'(switch_val));
      exp_ne = m_done && !m_mode && !m_found;
      if (!m_done) exp_disp = 0;
      else if (m_mode) exp_disp = m_sig;
      else if (m_found) exp_disp = m_cnt;
      else exp_disp = 0;
      chk("R2 src_addr", src_addr == W'(m_cnt), src_addr, m_cnt);
      chk("R9 done", done == m_done, done, m_done);
      chk("R5 shift_en", shift_en == exp_en, shift_en, exp_en);
      chk("R6 no_err", no_err == exp_ne, no_err, exp_ne);
      chk("R3 R10 display", int'(display) == exp_disp, display, exp_disp);
    end
  end

  task automatic do_run(input bit mode, input logic [W-1:0] sw, input int flip_at,
                        output int cycles);
    @(posedge clk); #2;
    rst_n = 1'b0; mode_sel = mode; switch_val = sw;
    @(posedge clk); @(posedge clk); #2;
    chk("R1 reset done", done == 1'b0, done, 0);
    chk("R1 reset addr", src_addr == '0, src_addr, 0);
    chk("R1 reset display", display == '0, display, 0);
    rst_n = 1'b1;
    cycles = 0;
    while (!done && cycles < 400) begin
      @(posedge clk); #2;
      cycles++;
      if (cycles == flip_at) mode_sel = ~mode_sel;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc, s_raw, syn, par;
    logic [W-1:0] held_disp, held_addr;
    logic [N-1:0] cw, bad;

    for (int i = 0; i < N; i++) stream[i] = 1'(((i * i * 7 + i * 3 + 1) >> 2) & 1);

    // check mode on raw stream (R2, R3, R4)
    do_run(1'b1, 8'h00, -1, cyc);
    s_raw = rem_prefix(stream, N);
    chk("R2 check length", cyc == 256, cyc, 256);
    chk("R3 R4 signature", int'(display) == s_raw, display, s_raw);
    chk("R7 flag", no_err == 1'b0, no_err, 0);

    // hold after done (R9)
    held_disp = display; held_addr = src_addr;
    repeat (12) @(posedge clk);
    #2;
    chk("R9 display held", display == held_disp, display, held_disp);
    chk("R9 addr held", src_addr == held_addr, src_addr, held_addr);
    chk("R9 no shift", shift_en == 1'b0, shift_en, 0);

    // codeword gives zero (R4)
    cw = stream;
    for (int j = 0; j < 8; j++) cw[248 + j] = 1'b0;
    par = rem_prefix(cw, N);
    for (int j = 0; j < 8; j++) cw[248 + j] = 1'((par >> (7 - j)) & 1);
    stream = cw;
    do_run(1'b1, 8'h00, -1, cyc);
    chk("R4 codeword zero", display == '0, display, 0);

    // single error at index 100 then locate (R4, R5)
    bad = cw; bad[100] = ~bad[100];
    stream = bad;
    syn = power_of_x(155);
    do_run(1'b1, 8'h00, -1, cyc);
    chk("R4 error syndrome", int'(display) == syn, display, syn);
    do_run(1'b0, W'(syn), -1, cyc);
    chk("R5 position q=100", int'(display) == 155, display, 155);
    chk("R5 found flag", no_err == 1'b0, no_err, 0);
    chk("R5 stop cycle", cyc == 156, cyc, 156);

    // error at index 1 (R5)
    syn = power_of_x(254);
    do_run(1'b0, W'(syn), -1, cyc);
    chk("R5 position q=1", int'(display) == 254, display, 254);

    // error in last bit: matches at once (R5)
    do_run(1'b0, 8'h01, -1, cyc);
    chk("R5 last bit pos", display == '0, display, 0);
    chk("R5 last bit flag", no_err == 1'b0, no_err, 0);
    chk("R5 last bit cycles", cyc == 1, cyc, 1);

    // zero switch never matches (R6)
    do_run(1'b0, 8'h00, -1, cyc);
    chk("R6 no_err set", no_err == 1'b1, no_err, 1);
    chk("R6 display zero", display == '0, display, 0);
    chk("R6 full length", cyc == 256, cyc, 256);

    // switch value ignored in check mode (R7)
    stream = bad;
    syn = rem_prefix(bad, 100);
    do_run(1'b1, W'(syn), -1, cyc);
    chk("R7 full length", cyc == 256, cyc, 256);
    chk("R7 signature", int'(display) == rem_prefix(bad, N), display, rem_prefix(bad, N));

    // mode toggled mid-run ignored (R8)
    do_run(1'b1, 8'h00, 40, cyc);
    chk("R8 check unchanged", int'(display) == rem_prefix(bad, N), display, rem_prefix(bad, N));
    chk("R8 length", cyc == 256, cyc, 256);
    syn = power_of_x(155);
    do_run(1'b0, W'(syn), 20, cyc);
    chk("R8 locate unchanged", int'(display) == 155, display, 155);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule